// File: doc/BRIEF.md
# Fractional I2C System Clock Prescaler

This block derives the internal clock enable of an I2C engine from a faster peripheral clock. It emits a one-cycle `tick` pulse at a rate set by a 3-bit ratio code. Four codes pick fixed ratios of 2.5, 3, 5 and 6. The fractional ratio of 2.5 is made by alternating tick intervals of 2 and 3 cycles. The all-zero code hands the choice to a 2-bit legacy selector, whose four ratios are parameters.

Every change of the effective setting restarts the divider, so the first tick after a change arrives one full period later. A legacy selector change counts only while the ratio code is zero. The three reserved codes stop all ticks and raise `cfg_err` until a valid code is applied.

Top module: `i2c_clk_prescaler`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `tick` and `cfg_err` are 0.
- R2: With `ratio_code` = 3'b001, the tick intervals are 2 cycles, then 3 cycles, then 2, then 3, and so on. This gives 2 ticks in every 5 clocks, and the first interval after a change is the 2-cycle one.
- R3: Codes 3'b010, 3'b011 and 3'b100 give a tick every 3, 5 and 6 cycles respectively.
- R4: With `ratio_code` = 3'b000, `legacy_sel` values 0, 1, 2 and 3 give a tick every LEG_DIV0, LEG_DIV1, LEG_DIV2 and LEG_DIV3 cycles.
- R5: The load edge is the first rising clock edge at which the effective setting differs from the stored one. `tick` is low in the cycle after the load edge. The first tick is the cycle after the rising edge that falls one full period after the load edge.
- R6: Codes 3'b101, 3'b110 and 3'b111 produce no ticks. They hold `cfg_err` at 1 from the cycle after the load edge onward.
- R7: `tick` is never high in two consecutive cycles.
- R8: While `ratio_code` is nonzero, a change of `legacy_sel` does not restart or alter the tick sequence.
- R9: When a reserved code is replaced by a valid one, `cfg_err` is 0 from the cycle after the load edge, and ticks resume per R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Ratio code; 000 selects the legacy selector |
| legacy_sel | input | 2 | Legacy ratio select, used when the code is 000 |
| tick | output | 1 | One-cycle clock enable pulse |
| cfg_err | output | 1 | High while a reserved code is in effect |

## Verification
The bench builds the block with legacy ratios of 3, 4, 7 and 9 instead of the defaults. This keeps every legacy period short enough to observe several full periods per case. It also adds odd and small ratios, which stress the counter wrap next to the fixed codes. Each scenario checks `tick` and `cfg_err` cycle by cycle from the load edge against a pattern computed from the period. That reaches the alternating 2.5 pattern, mid-period restarts, ignored legacy changes and recovery from reserved codes.

// File: rtl/i2c_clk_prescaler.sv
module i2c_clk_prescaler #(
  parameter int LEG_DIV0 = 4,
  parameter int LEG_DIV1 = 8,
  parameter int LEG_DIV2 = 16,
  parameter int LEG_DIV3 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_code,
  input  logic [1:0] legacy_sel,
  output logic       tick,
  output logic       cfg_err
);
  localparam int MAX_A   = (LEG_DIV0 > LEG_DIV1) ? LEG_DIV0 : LEG_DIV1;
  localparam int MAX_B   = (LEG_DIV2 > LEG_DIV3) ? LEG_DIV2 : LEG_DIV3;
  localparam int MAX_L   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_DIV = (MAX_L > 6) ? MAX_L : 6;
  localparam int CNT_W   = $clog2(MAX_DIV);

  logic [4:0]       eff_in, cfg_q;
  logic             cfg_vld, half, tick_q, reserved;
  logic [CNT_W-1:0] cnt, last;

  assign eff_in   = {ratio_code, (ratio_code == 3'b000) ? legacy_sel : 2'b00};
  assign reserved = cfg_q[4:2] >= 3'd5;
  assign cfg_err  = cfg_vld && reserved;
  assign tick     = tick_q;

  always_comb begin
    case (cfg_q[4:2])
      3'b000: begin
        case (cfg_q[1:0])
          2'd0:    last = CNT_W'(LEG_DIV0 - 1);
          2'd1:    last = CNT_W'(LEG_DIV1 - 1);
          2'd2:    last = CNT_W'(LEG_DIV2 - 1);
          default: last = CNT_W'(LEG_DIV3 - 1);
        endcase
      end
      3'b001:  last = half ? CNT_W'(2) : CNT_W'(1);
      3'b010:  last = CNT_W'(2);
      3'b011:  last = CNT_W'(4);
      3'b100:  last = CNT_W'(5);
      default: last = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cfg_vld <= 1'b0;
      cnt     <= '0;
      half    <= 1'b0;
      tick_q  <= 1'b0;
    end else if (!cfg_vld || eff_in != cfg_q) begin
      cfg_q   <= eff_in;
      cfg_vld <= 1'b1;
      cnt     <= '0;
      half    <= 1'b0;
      tick_q  <= 1'b0;
    end else if (reserved) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (cnt == last) begin
      cnt    <= '0;
      half   <= ~half;
      tick_q <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_q <= 1'b0;
    end
  end
endmodule

module i2c_clk_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] ratio_code,
  input logic       tick,
  input logic       cfg_err
);
  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !tick);

  assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(ratio_code) >= 3'd5));

  assert_err_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ratio_code >= 3'd5 && $past(ratio_code) >= 3'd5) |-> cfg_err);

  assert_restart_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code != $past(ratio_code)) |=> !tick);
endmodule

bind i2c_clk_prescaler i2c_clk_prescaler_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .tick(tick), .cfg_err(cfg_err)
);

// File: tb/i2c_clk_prescaler_test.sv
`timescale 1ns/1ps
module i2c_clk_prescaler_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ratio_code = 3'b010;
  logic [1:0] legacy_sel = 2'd0;
  logic tick, cfg_err;
  int vectors = 0, misses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_clk_prescaler #(.LEG_DIV0(3), .LEG_DIV1(4), .LEG_DIV2(7), .LEG_DIV3(9)) uut (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .legacy_sel(legacy_sel),
    .tick(tick), .cfg_err(cfg_err));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_tick(input bit frac, input int p, input int i);
    if (frac) return (i % 5 == 0) || (i % 5 == 2);
    return (i % p) == 0;
  endfunction

  // Applies a setting at a falling edge, then checks samples 1..n after the load edge.
  task automatic run_seq(input string req, input logic [2:0] code, input logic [1:0] leg,
                         input bit frac, input int p, input int n,
                         input int chg_at, input logic [1:0] new_leg);
    ratio_code = code;
    legacy_sel = leg;
    @(posedge clk);
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(req, "tick", tick, exp_tick(frac, p, i));
      check(req, "cfg_err", cfg_err, 1'b0);
      if (i == chg_at) legacy_sel = new_leg;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "tick in reset", tick, 1'b0);
    check("R1", "cfg_err in reset", cfg_err, 1'b0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "tick after release", tick, 1'b0);
    check("R1", "cfg_err after release", cfg_err, 1'b0);
  endtask

  task automatic t_frac;
    run_seq("R2", 3'b001, 2'd0, 1'b1, 0, 25, 0, 2'd0);
  endtask

  task automatic t_fixed;
    run_seq("R3", 3'b010, 2'd0, 1'b0, 3, 12, 0, 2'd0);
    run_seq("R3", 3'b011, 2'd0, 1'b0, 5, 15, 0, 2'd0);
    run_seq("R3", 3'b100, 2'd0, 1'b0, 6, 18, 0, 2'd0);
  endtask

  task automatic t_legacy;
    run_seq("R4", 3'b000, 2'd0, 1'b0, 3, 9, 0, 2'd0);
    run_seq("R4", 3'b000, 2'd1, 1'b0, 4, 12, 0, 2'd0);
    run_seq("R4", 3'b000, 2'd2, 1'b0, 7, 14, 0, 2'd0);
    run_seq("R4", 3'b000, 2'd3, 1'b0, 9, 18, 0, 2'd0);
  endtask

  task automatic t_restart;
    run_seq("R5", 3'b100, 2'd0, 1'b0, 6, 4, 0, 2'd0);
    run_seq("R5", 3'b010, 2'd0, 1'b0, 3, 7, 0, 2'd0);
    run_seq("R5", 3'b000, 2'd3, 1'b0, 9, 5, 0, 2'd0);
    run_seq("R5", 3'b000, 2'd1, 1'b0, 4, 8, 0, 2'd0);
  endtask

  task automatic t_ignore_legacy;
    run_seq("R8", 3'b011, 2'd0, 1'b0, 5, 17, 3, 2'd2);
    run_seq("R8", 3'b001, 2'd1, 1'b1, 0, 15, 6, 2'd3);
  endtask

  task automatic t_reserved;
    for (int c = 5; c <= 7; c++) begin
      ratio_code = 3'(c);
      @(posedge clk);
      for (int i = 1; i <= 10; i++) begin
        @(posedge clk);
        @(negedge clk);
        check("R6", "tick on reserved", tick, 1'b0);
        check("R6", "cfg_err on reserved", cfg_err, 1'b1);
        check("R7", "no tick", tick, 1'b0);
      end
      run_seq("R9", 3'b010, 2'd0, 1'b0, 3, 7, 0, 2'd0);
    end
  endtask

  task automatic t_single;
    logic prev;
    ratio_code = 3'b001;
    @(posedge clk);
    @(negedge clk);
    prev = tick;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R7", "tick pair", prev & tick, 1'b0);
      prev = tick;
    end
  endtask

  initial begin
    t_reset();
    t_frac();
    t_fixed();
    t_legacy();
    t_restart();
    t_ignore_legacy();
    t_reserved();
    t_single();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule